// File: doc/BRIEF.md
# Keyed Configuration Window for a Multi-UART Controller

This block is the chip-side configuration space of an I/O controller that carries several UARTs. A host reaches it through a two-byte window: offset 0 is the index port, offset 1 is the data port. The space is locked after reset. The host opens it by writing the same key byte to the index port twice in a row, and closes it again with the exit byte 0xAA. The host normally writes 0xAA before the key pair, so that an unlock left half-done is cleared first.

While the space is open, an index write selects a register and data-port accesses read or write that register. Four global registers report vendor and chip identity and cannot be written. Register 0x07 holds the logical device number, which picks the UART bank that the banked registers address. Each bank holds the UART's 16-bit I/O base, its interrupt mode, its RS485 and clock-select byte and its FIFO control byte. The decoded fields of every bank are driven out in parallel to the UARTs.

Host accesses arrive on a valid/ready request channel. A read returns its byte on a valid/ready response channel. One read may be outstanding at a time. While a response is held and `rsp_ready` is low, `acc_ready` is low and no new access of any kind is accepted. Writes produce no response.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, `rsp_valid` is 0 and `acc_ready` is 1. Each bank's I/O base holds its per-device reset value and every other bank field is 0.
- R2: The space opens only after the configured key is written to the index port on two consecutive index writes. The key is selected by `KEY_SEL` from 0x77, 0xA0, 0x87 and 0x67 (index 0 to 3; the default is 2, giving 0x87). A pair of any other byte does not open it. Data-port accesses do not break the sequence.
- R3: An index-port write of 0xAA locks the space in the same cycle, from any state, and clears a half-entered key.
- R4: If the second index write after a first key byte is not the key, the sequence restarts. A key byte written afterwards counts as a new first key.
- R5: While locked, reads of either port return 0xFF, data-port writes have no effect, and index writes only feed the key detector.
- R6: While open, register 0x23 reads 0x19 and register 0x24 reads 0x34. Register 0x20 reads the chip identity low byte and 0x21 the high byte (default 0x02, 0x08). Writes to these four registers are ignored.
- R7: Register 0x07 stores the written device number and reads it back. Banked registers address bank N when the number is N < NDEV. For a number of NDEV or more, banked registers read 0x00 and writes to them are ignored.
- R8: In a bank, register 0x61 is the low byte and 0x60 the high byte of the 16-bit I/O base, driven on `dev_base[16*N +: 16]`.
- R9: In a bank, register 0x70 bit 4 drives `dev_irq_share[N]`, and bits 6:5 drive `dev_irq_mode[2*N +: 2]` (00 = level/active-low, 01 = edge/active-high).
- R10: In a bank, register 0xF0 bits 5, 4, 3 and 2 (RTS invert, auto direction, receive delay, transmit delay) drive `dev_rs485[4*N +: 4]` in that order, MSB first. Bits 1:0 drive `dev_clk_sel[2*N +: 2]` (00 1.8432 MHz, 01 18.432 MHz, 10 24 MHz, 11 14.769 MHz).
- R11: In a bank, register 0xF6 drives `dev_fifo_deep[N]` high exactly when bits 1:0 are 11 (128-byte FIFO). It drives `dev_rx_thr4[N]` high exactly when bits 5:4 are 10 (four-times receive threshold).
- R12: A read accepted in one cycle presents `rsp_valid` with its byte from the next cycle. The byte is held stable until `rsp_ready` is high, and `acc_ready` stays low meanwhile.
- R13: While open, an index-port read returns the selected index, and a data-port read of any unlisted register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request valid |
| acc_ready | output | 1 | Access can be accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| dev_base | output | 16*NDEV | I/O base per device |
| dev_irq_share | output | NDEV | IRQ share flag per device |
| dev_irq_mode | output | 2*NDEV | IRQ mode per device |
| dev_rs485 | output | 4*NDEV | {RTS invert, auto dir, RX delay, TX delay} per device |
| dev_clk_sel | output | 2*NDEV | UART clock select per device |
| dev_fifo_deep | output | NDEV | 128-byte FIFO selected per device |
| dev_rx_thr4 | output | NDEV | Four-times RX threshold per device |

## Verification
The hardest states to reach are the half-entered key states: any index write used to ask a question disturbs the sequence. The bench probes the key detector only with data-port reads, which return 0xFF while locked and leave the sequence untouched. It drives orderings that interleave exit bytes and mismatched bytes between key bytes. A full sweep then writes and reads back every index in every device number, including numbers beyond the last bank, against an arithmetic model of the register file.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] EXIT_CODE   = 8'hAA;
  localparam logic [7:0] IX_DEVNUM   = 8'h07;
  localparam logic [7:0] IX_CHIP_LO  = 8'h20;
  localparam logic [7:0] IX_CHIP_HI  = 8'h21;
  localparam logic [7:0] IX_VEND_A   = 8'h23;
  localparam logic [7:0] IX_VEND_B   = 8'h24;
  localparam logic [7:0] VEND_A_VAL  = 8'h19;
  localparam logic [7:0] VEND_B_VAL  = 8'h34;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] IX_IRQ      = 8'h70;
  localparam logic [7:0] IX_LINE     = 8'hF0;
  localparam logic [7:0] IX_FIFO     = 8'hF6;

  typedef enum logic [1:0] {GATE_SHUT, GATE_HALF, GATE_OPEN} gate_t;

  function automatic logic [7:0] key_of(input int unsigned sel);
    case (sel)
      0:       return 8'h77;
      1:       return 8'hA0;
      2:       return 8'h87;
      default: return 8'h67;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_gate.sv
module sio_key_gate
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] idx_data,
  output logic       open
);
  gate_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= GATE_SHUT;
    end else if (idx_wr) begin
      if (idx_data == EXIT_CODE) begin
        st <= GATE_SHUT;
      end else begin
        case (st)
          GATE_SHUT: st <= (idx_data == KEY) ? GATE_HALF : GATE_SHUT;
          GATE_HALF: st <= (idx_data == KEY) ? GATE_OPEN : GATE_SHUT;
          default:   st <= GATE_OPEN;
        endcase
      end
    end
  end

  assign open = (st == GATE_OPEN);

  p_exit_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && idx_data == EXIT_CODE) |=> !open);

  p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(idx_wr && idx_data == KEY));

  p_half_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GATE_HALF && idx_wr && idx_data != KEY) |=> !open);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_RST = 16'h03F8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [15:0] base,
  output logic        irq_share,
  output logic [1:0]  irq_mode,
  output logic [3:0]  rs485,
  output logic [1:0]  clk_sel,
  output logic        fifo_deep,
  output logic        rx_thr4
);
  logic [7:0] base_lo, base_hi, irq_r, line_r, fifo_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo <= BASE_RST[7:0];
      base_hi <= BASE_RST[15:8];
      irq_r   <= '0;
      line_r  <= '0;
      fifo_r  <= '0;
    end else if (sel && wr) begin
      case (idx)
        IX_BASE_LO: base_lo <= wdata;
        IX_BASE_HI: base_hi <= wdata;
        IX_IRQ:     irq_r   <= wdata;
        IX_LINE:    line_r  <= wdata;
        IX_FIFO:    fifo_r  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_BASE_LO: rdata = base_lo;
      IX_BASE_HI: rdata = base_hi;
      IX_IRQ:     rdata = irq_r;
      IX_LINE:    rdata = line_r;
      IX_FIFO:    rdata = fifo_r;
      default:    rdata = 8'h00;
    endcase
  end

  assign base      = {base_hi, base_lo};
  assign irq_share = irq_r[4];
  assign irq_mode  = irq_r[6:5];
  assign rs485     = line_r[5:2];
  assign clk_sel   = line_r[1:0];
  assign fifo_deep = (fifo_r[1:0] == 2'b11);
  assign rx_thr4   = (fifo_r[5:4] == 2'b10);

  p_unsel_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable({base_lo, base_hi, irq_r, line_r, fifo_r}));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned        KEY_SEL  = 2,
  parameter int unsigned        NDEV     = 5,
  parameter logic [15:0]        CHIP_ID  = 16'h0802,
  parameter logic [NDEV*16-1:0] BASE_RST = 80'h0220_02E8_03E8_02F8_03F8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic                 acc_write,
  input  logic                 acc_offset,
  input  logic [7:0]           acc_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [7:0]           rsp_data,
  output logic [NDEV*16-1:0]   dev_base,
  output logic [NDEV-1:0]      dev_irq_share,
  output logic [NDEV*2-1:0]    dev_irq_mode,
  output logic [NDEV*4-1:0]    dev_rs485,
  output logic [NDEV*2-1:0]    dev_clk_sel,
  output logic [NDEV-1:0]      dev_fifo_deep,
  output logic [NDEV-1:0]      dev_rx_thr4
);
  localparam logic [7:0] KEY = key_of(KEY_SEL);

  logic       fire, rd_fire, idx_wr, dat_wr, open;
  logic [7:0] index_q, devnum_q, rd_mux, bank_sel_rd;
  logic [7:0] bank_rd [NDEV];

  assign acc_ready = !rsp_valid || rsp_ready;
  assign fire      = acc_valid && acc_ready;
  assign rd_fire   = fire && !acc_write;
  assign idx_wr    = fire && acc_write && !acc_offset;
  assign dat_wr    = fire && acc_write && acc_offset && open;

  sio_key_gate #(.KEY(KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(acc_wdata), .open(open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q  <= '0;
      devnum_q <= '0;
    end else begin
      if (idx_wr && open && acc_wdata != EXIT_CODE) index_q <= acc_wdata;
      if (dat_wr && index_q == IX_DEVNUM) devnum_q <= acc_wdata;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_bank
    logic sel_i;
    assign sel_i = (devnum_q == 8'(i));
    sio_dev_bank #(.BASE_RST(BASE_RST[16*i +: 16])) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(sel_i), .wr(dat_wr), .idx(index_q),
      .wdata(acc_wdata), .rdata(bank_rd[i]),
      .base(dev_base[16*i +: 16]), .irq_share(dev_irq_share[i]),
      .irq_mode(dev_irq_mode[2*i +: 2]), .rs485(dev_rs485[4*i +: 4]),
      .clk_sel(dev_clk_sel[2*i +: 2]), .fifo_deep(dev_fifo_deep[i]),
      .rx_thr4(dev_rx_thr4[i])
    );
  end

  always_comb begin
    bank_sel_rd = 8'h00;
    for (int i = 0; i < NDEV; i++)
      if (devnum_q == 8'(i)) bank_sel_rd = bank_rd[i];
  end

  always_comb begin
    if (!open) begin
      rd_mux = 8'hFF;
    end else if (!acc_offset) begin
      rd_mux = index_q;
    end else begin
      case (index_q)
        IX_CHIP_LO: rd_mux = CHIP_ID[7:0];
        IX_CHIP_HI: rd_mux = CHIP_ID[15:8];
        IX_VEND_A:  rd_mux = VEND_A_VAL;
        IX_VEND_B:  rd_mux = VEND_B_VAL;
        IX_DEVNUM:  rd_mux = devnum_q;
        default:    rd_mux = bank_sel_rd;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_read_answers_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  p_locked_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !open) |=> (rsp_data == 8'hFF));
endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  localparam int NDEV = 5;
  localparam logic [7:0] KEY = 8'h87;
  localparam logic [NDEV*16-1:0] BRST = 80'h0220_02E8_03E8_02F8_03F8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_offset = 0, rsp_ready = 1;
  logic [7:0] acc_wdata = 0;
  logic acc_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [NDEV*16-1:0] dev_base;
  logic [NDEV-1:0] dev_irq_share, dev_fifo_deep, dev_rx_thr4;
  logic [NDEV*2-1:0] dev_irq_mode, dev_clk_sel;
  logic [NDEV*4-1:0] dev_rs485;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m [NDEV][5];
  logic [7:0] cur_dev = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  sio_cfg_port u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic off, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_offset = off; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic off, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_offset = off;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    d = rsp_data;
    if (!rsp_valid) begin
      bad++; total++;
      $display("FAIL R12 actual=rsp_valid 0 expected=1");
    end
  endtask

  function automatic int slot(input logic [7:0] a);
    case (a)
      8'h61: return 0;
      8'h60: return 1;
      8'h70: return 2;
      8'hF0: return 3;
      8'hF6: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    case (a)
      8'h20: return 8'h02;
      8'h21: return 8'h08;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      8'h07: return cur_dev;
      default: begin
        if (slot(a) >= 0 && cur_dev < NDEV) return m[cur_dev][slot(a)];
        return 8'h00;
      end
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h07) cur_dev = d;
    else if (slot(a) >= 0 && cur_dev < NDEV) m[cur_dev][slot(a)] = d;
  endtask

  task automatic unlock();
    wr(0, 8'hAA); wr(0, KEY); wr(0, KEY);
  endtask

  task automatic check_ports(input string tag);
    for (int d = 0; d < NDEV; d++) begin
      chk({tag, " R8 base"}, dev_base[16*d +: 16], {m[d][1], m[d][0]});
      chk({tag, " R9 irq"}, {dev_irq_share[d], dev_irq_mode[2*d +: 2]},
          {m[d][2][4], m[d][2][6:5]});
      chk({tag, " R10 line"}, {dev_rs485[4*d +: 4], dev_clk_sel[2*d +: 2]},
          {m[d][3][5:2], m[d][3][1:0]});
      chk({tag, " R11 fifo"}, {dev_fifo_deep[d], dev_rx_thr4[d]},
          {m[d][4][1:0] == 2'b11, m[d][4][5:4] == 2'b10});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDEV; d++) begin
      m[d][0] = BRST[16*d +: 8]; m[d][1] = BRST[16*d+8 +: 8];
      m[d][2] = 0; m[d][3] = 0; m[d][4] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 acc_ready", acc_ready, 1);
    check_ports("R1");
    // R5 locked reads and ignored writes
    rd(1, got); chk("R5 locked data read", got, 8'hFF);
    rd(0, got); chk("R5 locked index read", got, 8'hFF);
    wr(0, 8'h61); wr(1, 8'h5A);
    check_ports("R5 locked write");
    // R2 a wrong key pair does not open
    wr(0, 8'hAA); wr(0, 8'h77); wr(0, 8'h77);
    rd(1, got); chk("R2 wrong key", got, 8'hFF);
    // R3 exit clears a half entry
    wr(0, 8'hAA); wr(0, KEY); wr(0, 8'hAA); wr(0, KEY);
    rd(1, got); chk("R3 half cleared", got, 8'hFF);
    // R4 mismatch restarts; later key counts as first
    wr(0, 8'hAA); wr(0, KEY); wr(0, 8'h55);
    rd(1, got); chk("R4 after mismatch", got, 8'hFF);
    wr(0, KEY);
    rd(1, got); chk("R4 one key only", got, 8'hFF);
    wr(0, KEY);
    // R2 data reads between keys did not disturb: now open
    wr(0, 8'h23); rd(1, got); chk("R2 open vendor", got, 8'h19);
    // R6 identity, writes ignored
    wr(0, 8'h24); rd(1, got); chk("R6 vendor b", got, 8'h34);
    wr(0, 8'h20); wr(1, 8'hEE); rd(1, got); chk("R6 chip lo", got, 8'h02);
    wr(0, 8'h21); wr(1, 8'hEE); rd(1, got); chk("R6 chip hi", got, 8'h08);
    wr(0, 8'h23); wr(1, 8'h00); rd(1, got); chk("R6 vendor a ro", got, 8'h19);
    // R13 index read-back and unlisted register
    rd(0, got); chk("R13 index read", got, 8'h23);
    wr(0, 8'h42); rd(1, got); chk("R13 unlisted", got, 8'h00);
    // R9 R10 R11 specific field codes on device 2
    wr(0, 8'h07); wr(1, 8'h02); model_wr(8'h07, 8'h02);
    wr(0, 8'h70); wr(1, 8'h50); model_wr(8'h70, 8'h50);
    wr(0, 8'hF0); wr(1, 8'h2D); model_wr(8'hF0, 8'h2D);
    wr(0, 8'hF6); wr(1, 8'h23); model_wr(8'hF6, 8'h23);
    chk("R9 share", dev_irq_share[2], 1);
    chk("R9 mode", dev_irq_mode[5:4], 2'b10);
    chk("R10 rs485", dev_rs485[11:8], 4'b1011);
    chk("R10 clk", dev_clk_sel[5:4], 2'b01);
    chk("R11 deep+thr", {dev_fifo_deep[2], dev_rx_thr4[2]}, 2'b11);
    wr(1, 8'h13); model_wr(8'hF6, 8'h13);
    chk("R11 deep only", {dev_fifo_deep[2], dev_rx_thr4[2]}, 2'b10);
    wr(1, 8'h22); model_wr(8'hF6, 8'h22);
    chk("R11 thr only", {dev_fifo_deep[2], dev_rx_thr4[2]}, 2'b01);
    // R7 R8 sweep over device numbers 0..7 and all indexes
    for (int dn = 0; dn < 8; dn++) begin
      wr(0, 8'h07); wr(1, 8'(dn)); model_wr(8'h07, 8'(dn));
      rd(1, got); chk("R7 devnum readback", got, dn);
      for (int a = 0; a < 256; a++) begin
        if (a == 8'hAA || a == 8'h07) continue;
        wr(0, 8'(a)); wr(1, 8'((a * 7 + dn * 13 + 1) & 255));
        model_wr(8'(a), 8'((a * 7 + dn * 13 + 1) & 255));
      end
      for (int a = 0; a < 256; a++) begin
        if (a == 8'hAA || a == 8'h07) continue;
        wr(0, 8'(a)); rd(1, got);
        chk("R7 R8 sweep", {dn[7:0], 8'(a), got}, {dn[7:0], 8'(a), model_rd(8'(a))});
      end
    end
    check_ports("R8 sweep");
    // R12 back-pressure
    wr(0, 8'h23);
    @(negedge clk); rsp_ready = 0; acc_valid = 1; acc_write = 0; acc_offset = 1;
    @(posedge clk); @(negedge clk); acc_valid = 0;
    chk("R12 valid", rsp_valid, 1);
    chk("R12 ready low", acc_ready, 0);
    repeat (3) @(negedge clk);
    chk("R12 held valid", rsp_valid, 1);
    chk("R12 held data", rsp_data, 8'h19);
    rsp_ready = 1;
    @(negedge clk);
    chk("R12 consumed", rsp_valid, 0);
    // R3 exit from open, R5 write while locked ignored
    wr(0, 8'h07); wr(1, 8'h01); model_wr(8'h07, 8'h01);
    wr(0, 8'h61); wr(0, 8'hAA);
    rd(1, got); chk("R3 exit from open", got, 8'hFF);
    wr(1, 8'hC3);
    wr(0, KEY); wr(0, KEY);
    rd(1, got); chk("R5 locked write ignored", got, model_rd(8'h61));
    check_ports("R5 final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule